// File: doc/BRIEF.md
# Runtime Group Precision Detector

This block looks at a group of non-negative activations that a bit-serial engine will process together. It works out how many bit-planes are needed to represent every member of the group. Any plane above the highest set bit in the group holds only zeros, so the engine can skip those planes and finish the group in fewer cycles. Software supplies a per-layer precision, and the detected value is never allowed to exceed that bound.

The OR-reduction stage works bit position by bit position. It merges all members of the group into an occupancy vector, in which a bit is set when at least one member has a one in that position. A leading-one detector finds the highest set bit of that vector. The precision is that bit's index plus one. An empty group yields one plane rather than zero, so the engine always runs at least one pass. The result is then limited to the layer precision and registered.

A two-state output machine issues the result. It moves from IDLE to LIVE on a cycle with the group strobe. It stays in LIVE while strobes keep arriving, and returns from LIVE to IDLE on a cycle without one. While in LIVE the output valid is high. In IDLE the last precision is held.

Top module: `gpd_detector`

## Requirements
- R1: After reset, `prec_valid` is 0 and `prec_out` is 1.
- R2: `prec_valid` is 1 in the cycle after a cycle with `grp_valid` high, and is 0 in the cycle after a cycle with `grp_valid` low.
- R3: With `grp_valid` high, the precision computed before any limit is p+1. Here p is the highest bit position, with bit 0 as the least significant bit, that is set in any member of the group.
- R4: A group whose members are all zero yields a precision of 1.
- R5: When `layer_prec` is smaller than the detected precision, `prec_out` equals `layer_prec`.
- R6: A `layer_prec` of 0 yields a `prec_out` of 1.
- R7: A `layer_prec` greater than or equal to the detected precision has no effect, so `prec_out` equals the detected precision.
- R8: While `grp_valid` is low, `prec_out` keeps its value whatever `grp_data` and `layer_prec` do.
- R9: Every member slot contributes equally. Member i occupies bits [i*WIDTH +: WIDTH] of `grp_data`, and a set bit in any slot raises the precision in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | Strobe: a group is present on `grp_data` this cycle |
| grp_data | input | GROUP*WIDTH | Flattened group; member i at bits [i*WIDTH +: WIDTH] |
| layer_prec | input | PREC_W | Per-layer precision bound, sampled with the strobe |
| prec_valid | output | 1 | High for one cycle per accepted group |
| prec_out | output | PREC_W | Registered group precision, 1..WIDTH |

## Verification
The assertions assume that `grp_data` and `layer_prec` carry known values on every strobe cycle. Between strobes they may take any value. The bench drives all inputs at the falling edge and keeps them at defined values from time zero, including idle cycles in which it changes data without a strobe. A small configuration of four members of six bits is swept over every highest bit position, every member slot and every layer bound from 0 to 7. This covers the empty group, the case where the bound wins and the case where the bound has no effect.

// File: rtl/gpd_pkg.sv
package gpd_pkg;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_LIVE = 1'b1
    } out_state_t;

endpackage

// File: rtl/gpd_or_plane.sv
module gpd_or_plane #(
    parameter int GROUP = 256,
    parameter int WIDTH = 16
) (
    input  logic [GROUP*WIDTH-1:0] members,
    output logic [WIDTH-1:0]       occupancy
);

    // One OR tree per bit position across all members of the group.
    for (genvar b = 0; b < WIDTH; b++) begin : g_plane
        logic [GROUP-1:0] column;
        for (genvar m = 0; m < GROUP; m++) begin : g_member
            assign column[m] = members[m*WIDTH + b];
        end
        assign occupancy[b] = |column;
    end

endmodule

// File: rtl/gpd_lead_one.sv
module gpd_lead_one #(
    parameter int WIDTH = 16,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IDX_W-1:0] top_idx,
    output logic             any_set
);

    always_comb begin
        top_idx = '0;
        any_set = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i]) begin
                top_idx = IDX_W'(i);
                any_set = 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpd_detector.sv
module gpd_detector
    import gpd_pkg::*;
#(
    parameter int GROUP = 256,
    parameter int WIDTH = 16,
    localparam int IDX_W  = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int PREC_W = $clog2(WIDTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   grp_valid,
    input  logic [GROUP*WIDTH-1:0] grp_data,
    input  logic [PREC_W-1:0]      layer_prec,
    output logic                   prec_valid,
    output logic [PREC_W-1:0]      prec_out
);

    logic [WIDTH-1:0]  occupancy;
    logic [IDX_W-1:0]  top_idx;
    logic              any_set;
    logic [PREC_W-1:0] detected;
    logic [PREC_W-1:0] capped;
    logic [PREC_W-1:0] final_prec;
    out_state_t        state_q;
    out_state_t        state_d;

    gpd_or_plane #(.GROUP(GROUP), .WIDTH(WIDTH)) u_plane (
        .members   (grp_data),
        .occupancy (occupancy)
    );

    gpd_lead_one #(.WIDTH(WIDTH)) u_lead (
        .vec     (occupancy),
        .top_idx (top_idx),
        .any_set (any_set)
    );

    always_comb begin
        detected   = any_set ? (PREC_W'(top_idx) + PREC_W'(1)) : PREC_W'(1);
        capped     = (layer_prec < detected) ? layer_prec : detected;
        final_prec = (capped == '0) ? PREC_W'(1) : capped;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: if (grp_valid)  state_d = OUT_LIVE;
            OUT_LIVE: if (!grp_valid) state_d = OUT_IDLE;
            default:                  state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         prec_out <= PREC_W'(1);
        else if (grp_valid) prec_out <= final_prec;
    end

    assign prec_valid = (state_q == OUT_LIVE);

    // R2: output valid follows the strobe by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |=> prec_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid |=> !prec_valid);
    // R8: precision held without strobe
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid |=> $stable(prec_out));
    // R4: empty group gives one plane
    a_r4_empty_group: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && grp_data == '0) |=> prec_out == PREC_W'(1));
    // R5: never above the layer bound unless the floor applies
    a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |=> (prec_out <= $past(layer_prec) || prec_out == PREC_W'(1)));
    // R6: never zero planes
    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        prec_out != '0);

endmodule

// File: tb/sim_gpd_detector.sv
module sim_gpd_detector;

    localparam int GROUP  = 4;
    localparam int WIDTH  = 6;
    localparam int PREC_W = $clog2(WIDTH + 1);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   grp_valid = 1'b0;
    logic [GROUP*WIDTH-1:0] grp_data = '0;
    logic [PREC_W-1:0]      layer_prec = '0;
    logic                   prec_valid;
    logic [PREC_W-1:0]      prec_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpd_detector #(.GROUP(GROUP), .WIDTH(WIDTH)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_valid  (grp_valid),
        .grp_data   (grp_data),
        .layer_prec (layer_prec),
        .prec_valid (prec_valid),
        .prec_out   (prec_out)
    );

    function automatic int expect_prec(logic [GROUP*WIDTH-1:0] d, int layer);
        int hi = -1;
        int det;
        int r;
        for (int m = 0; m < GROUP; m++)
            for (int b = 0; b < WIDTH; b++)
                if (d[m*WIDTH + b] && b > hi) hi = b;
        det = hi + 1;
        if (det < 1) det = 1;
        r = (layer < det) ? layer : det;
        if (r < 1) r = 1;
        return r;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(logic [GROUP*WIDTH-1:0] d, int layer, string req);
        int e;
        @(negedge clk);
        grp_valid  = 1'b1;
        grp_data   = d;
        layer_prec = PREC_W'(layer);
        e = expect_prec(d, layer);
        @(negedge clk);
        grp_valid = 1'b0;
        check({req, " valid"}, int'(prec_valid), 1);
        check(req, int'(prec_out), e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", int'(prec_valid), 0);
        check("R1 prec", int'(prec_out), 1);
        rst_n = 1'b1;

        // R4: empty group, generous bound
        send('0, 7, "R4");
        // R3: top bit in each position, single member
        for (int p = 0; p < WIDTH; p++) send((GROUP*WIDTH)'(1) << p, WIDTH, "R3");

        // R9 / R5 / R6 / R7 sweep: slot, top position, layer bound
        for (int layer = 0; layer < 8; layer++) begin
            for (int p = -1; p < WIDTH; p++) begin
                for (int s = 0; s < GROUP; s++) begin
                    logic [GROUP*WIDTH-1:0] d = '0;
                    if (p >= 0) begin
                        for (int m = 0; m < GROUP; m++)
                            d[m*WIDTH +: WIDTH] = WIDTH'(((m + s) * 5) & ((1 << p) - 1));
                        d[s*WIDTH + p] = 1'b1;
                    end
                    if (layer == 0)                    send(d, layer, "R6");
                    else if (layer < expect_prec(d, 7)) send(d, layer, "R5");
                    else if (p >= 0)                    send(d, layer, "R9_R7");
                    else                                send(d, layer, "R4");
                end
            end
        end

        // R8 / R2: data churn without strobe leaves output untouched
        send(24'h000020, 7, "R3");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            grp_data   = 24'h000001 << k;
            layer_prec = PREC_W'(k);
            @(negedge clk);
            check("R2 idle valid", int'(prec_valid), 0);
            check("R8 hold", int'(prec_out), 6);
        end
        // R2: back-to-back strobes keep valid high
        @(negedge clk);
        grp_valid = 1'b1; grp_data = 24'h000004; layer_prec = 3'd7;
        @(negedge clk);
        check("R2 b2b valid", int'(prec_valid), 1);
        check("R3 b2b", int'(prec_out), 3);
        grp_data = 24'h800000;
        @(negedge clk);
        grp_valid = 1'b0;
        check("R2 b2b valid", int'(prec_valid), 1);
        check("R9 b2b", int'(prec_out), 6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule